// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is a 32-bit timer that counts down. A 16-bit prescaler sets its rate. Software writes a divide-down value, split into a low byte and a high byte. That value acts as a shadow: the running prescale count picks it up only when the count expires or when software requests a reload. Software can read the running prescale count but cannot write it. Each time the prescaler expires, the main counter steps down once. When the main counter is already at zero, that same step reloads it from a period register and marks a terminal-count event.

Software controls the timer through a simple one-cycle write bus and a combinational read bus. The control word holds four things: a stop bit, a reload strobe that clears itself, an interrupt enable, and a sticky terminal-count flag. Software clears the flag by writing 1 to it. The interrupt output is the flag gated by the enable.

Top module: `dntimer`

## Requirements
- R1: After reset, the following all read as zero: main count, period, divide-down value and prescale count. Stop reads as 1 and the flag reads as 0. The interrupt output is low.
- R2: While the timer is not stopped and the prescale count is above 0, the prescale count falls by exactly 1 on each clock.
- R3: On the clock after the prescale count reads 0 (running), two things happen. The prescale count loads the divide-down value, and the main counter falls by 1. The division ratio is therefore the divide-down value plus 1.
- R4: Writing a new divide-down value leaves the running prescale count unchanged. The new value first appears at the next expiry or reload.
- R5: Bus writes to the prescale-count fields and to the main-count register have no effect.
- R6: A write of 1 to CTRL bit 1 (reload) loads the prescale count from the divide-down value and the main counter from the period. This happens even while stopped, and the bit reads back as 0.
- R7: While CTRL bit 0 (stop) is 1, neither the prescale count nor the main counter changes, except through a reload.
- R8: When the prescaler expires with the main counter at 0, the main counter loads the period and CTRL bit 3 (flag) becomes 1.
- R9: The output irq is high exactly when the flag and CTRL bit 2 (interrupt enable) are both 1.
- R10: Writing 1 to CTRL bit 3 clears the flag. If a terminal-count event happens in the same cycle, the flag stays 1.
- R11: Register addresses are as follows:
  - 0: main count, read-only.
  - 1: period.
  - 2: CTRL.
  - 3: low byte of the divide-down value in [7:0], with the low byte of the prescale count read at [15:8].
  - 4: the same layout for the high bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Terminal-count interrupt |

## Verification
The in-module properties assume that the reload strobe and the stop bit are the only controls that can override counting. They also assume the bus offers at most one write per cycle, so a reload and a divide-down write never arrive together. The stimulus keeps to this. It issues one bus operation per clock, changes inputs only shortly after the rising edge, and never combines a reload with any write other than to CTRL. Shadow and set-wins timing are reached on purpose: writes are placed on precomputed cycles, mid-count and on the expiry edge.

// File: rtl/dntimer_pkg.sv
package dntimer_pkg;
   typedef enum logic [2:0] {
      ADR_COUNT  = 3'd0,
      ADR_PERIOD = 3'd1,
      ADR_CTRL   = 3'd2,
      ADR_DIVL   = 3'd3,
      ADR_DIVH   = 3'd4
   } dt_addr_e;

   localparam int CB_STOP   = 0;
   localparam int CB_RELOAD = 1;
   localparam int CB_IEN    = 2;
   localparam int CB_FLAG   = 3;
endpackage

// File: rtl/dt_prescaler.sv
module dt_prescaler #(
   parameter int PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             reload,
   input  logic [PSC_W-1:0] div_val,
   output logic [PSC_W-1:0] psc,
   output logic             expire
);
   localparam logic [PSC_W-1:0] ZERO = '0;

   assign expire = run && (psc == ZERO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               psc <= ZERO;
      else if (reload)          psc <= div_val;
      else if (run) begin
         if (psc == ZERO)       psc <= div_val;
         else                   psc <= psc - 1'b1;
      end
   end

   p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !reload && psc != ZERO) |=> psc == $past(psc) - 1'b1);
   p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !reload && psc == ZERO) |=> psc == $past(div_val));
   p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> psc == $past(div_val));
   p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !reload) |=> $stable(psc));
endmodule

// File: rtl/dt_counter.sv
module dt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             reload,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             tc
);
   localparam logic [CNT_W-1:0] ZERO = '0;

   assign tc = step && (cnt == ZERO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= ZERO;
      else if (reload)     cnt <= period;
      else if (step) begin
         if (cnt == ZERO)  cnt <= period;
         else              cnt <= cnt - 1'b1;
      end
   end

   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !reload && cnt != ZERO) |=> cnt == $past(cnt) - 1'b1);
   p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !reload && cnt == ZERO) |=> cnt == $past(period));
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !reload) |=> $stable(cnt));
endmodule

// File: rtl/dt_irqflag.sv
module dt_irqflag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag <= 1'b0;
      else if (set)  flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
   end

   p_setwins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag);
   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag);
   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
endmodule

// File: rtl/dntimer.sv
module dntimer
   import dntimer_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int BYTE_W  = 8,
   parameter int DATA_W  = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int PSC_W = 2 * BYTE_W;

   generate
      if (CNT_W > DATA_W)  begin : g_bad_cnt  $error("CNT_W exceeds DATA_W");  end
      if (PSC_W > DATA_W)  begin : g_bad_psc  $error("prescaler exceeds DATA_W"); end
      if (DATA_W < 4)      begin : g_bad_ctl  $error("DATA_W too narrow for CTRL"); end
   endgenerate

   logic [CNT_W-1:0] period_q;
   logic [PSC_W-1:0] div_q;
   logic             stop_q, ien_q;
   logic [PSC_W-1:0] psc;
   logic [CNT_W-1:0] cnt;
   logic             expire, tc, flag;
   logic             wr_ctrl, reload, clr;

   assign wr_ctrl = bus_we && (bus_addr == ADR_CTRL);
   assign reload  = wr_ctrl && bus_wdata[CB_RELOAD];
   assign clr     = wr_ctrl && bus_wdata[CB_FLAG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '0;
         div_q    <= '0;
         stop_q   <= 1'b1;
         ien_q    <= 1'b0;
      end else if (bus_we) begin
         case (bus_addr)
            ADR_PERIOD: period_q <= bus_wdata[CNT_W-1:0];
            ADR_CTRL: begin
               stop_q <= bus_wdata[CB_STOP];
               ien_q  <= bus_wdata[CB_IEN];
            end
            ADR_DIVL: div_q[BYTE_W-1:0]     <= bus_wdata[BYTE_W-1:0];
            ADR_DIVH: div_q[PSC_W-1:BYTE_W] <= bus_wdata[BYTE_W-1:0];
            default: ;
         endcase
      end
   end

   dt_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(!stop_q), .reload(reload),
      .div_val(div_q), .psc(psc), .expire(expire));

   dt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(expire), .reload(reload),
      .period(period_q), .cnt(cnt), .tc(tc));

   dt_irqflag u_flag (
      .clk(clk), .rst_n(rst_n), .set(tc), .clr(clr), .flag(flag));

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADR_COUNT:  bus_rdata = DATA_W'(cnt);
         ADR_PERIOD: bus_rdata = DATA_W'(period_q);
         ADR_CTRL: begin
            bus_rdata[CB_STOP] = stop_q;
            bus_rdata[CB_IEN]  = ien_q;
            bus_rdata[CB_FLAG] = flag;
         end
         ADR_DIVL:   bus_rdata = DATA_W'({psc[BYTE_W-1:0], div_q[BYTE_W-1:0]});
         ADR_DIVH:   bus_rdata = DATA_W'({psc[PSC_W-1:BYTE_W], div_q[PSC_W-1:BYTE_W]});
         default:    bus_rdata = '0;
      endcase
   end

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= flag && ien_q;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = flag && ien_q;
      end
   endgenerate

   p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && !$past(flag)) |-> !irq);
   p_shadow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADR_DIVL && !stop_q && psc != '0) |=> psc == $past(psc) - 1'b1);
endmodule

// File: tb/sim_dntimer.sv
`timescale 1ns/1ps
module sim_dntimer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      bit          is_irq;
      logic [2:0]  addr;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];

   always #10 clk = ~clk;

   dntimer u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
               .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = sb.pop_front();
         act = it.is_irq ? {31'd0, irq} : bus_rdata;
         checks++;
         if (act !== it.exp) begin
            fails++;
            $display("FAIL %s addr=%0d actual=0x%0h expected=0x%0h",
                     it.tag, it.addr, act, it.exp);
         end
      end
   end

   task automatic cyc();
      @(posedge clk); #2;
      bus_we = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      cyc();
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
   endtask

   task automatic chk(input logic [2:0] a, input logic [31:0] e, input string tag);
      item_t it;
      cyc();
      bus_addr = a;
      it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic chk_irq(input logic e, input string tag);
      item_t it;
      cyc();
      it.is_irq = 1'b1; it.addr = 3'd7; it.exp = {31'd0, e}; it.tag = tag;
      sb.push_back(it);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1 reset state (R11 map)
      chk(3'd0, 32'h0, "R1 count");
      chk(3'd1, 32'h0, "R1 period");
      chk(3'd2, 32'h1, "R1 ctrl");
      chk(3'd3, 32'h0, "R1 divl");
      chk(3'd4, 32'h0, "R1 divh");
      chk_irq(1'b0, "R1 irq");
      // R4/R5: divide-down write, prescale field untouched
      wr(3'd3, 32'h0000_AA05);
      chk(3'd3, 32'h0005, "R5 psc field read-only");
      wr(3'd1, 32'd3);
      wr(3'd0, 32'h1234);
      chk(3'd0, 32'h0, "R5 count read-only");
      // R6 reload while stopped
      wr(3'd2, 32'h3);
      chk(3'd0, 32'd3, "R6 count loaded");
      chk(3'd3, 32'h0505, "R6 psc loaded");
      chk(3'd2, 32'h1, "R6 reload reads 0");
      // R7 frozen while stopped
      cyc(); cyc(); cyc();
      chk(3'd0, 32'd3, "R7 count frozen");
      chk(3'd3, 32'h0505, "R7 psc frozen");
      // run
      wr(3'd2, 32'h0);
      chk(3'd3, 32'h0505, "R2 psc 5");
      chk(3'd3, 32'h0405, "R2 psc 4");
      chk(3'd3, 32'h0305, "R2 psc 3");
      chk(3'd0, 32'd3, "R3 count holds mid-prescale");
      chk(3'd0, 32'd3, "R3 count holds mid-prescale");
      chk(3'd3, 32'h0005, "R2 psc 0");
      chk(3'd0, 32'd2, "R3 count stepped");
      chk(3'd3, 32'h0405, "R3 psc reloaded");
      wr(3'd3, 32'h01);
      chk(3'd3, 32'h0201, "R4 shadow not applied");
      chk(3'd3, 32'h0101, "R4 shadow not applied");
      chk(3'd3, 32'h0001, "R4 psc 0");
      chk(3'd3, 32'h0101, "R4 new divide applied");
      chk(3'd0, 32'd1, "R3 count 1");
      chk(3'd0, 32'd0, "R3 count 0");
      chk(3'd2, 32'h0, "R8 flag not yet");
      chk(3'd0, 32'd3, "R8 count reload from period");
      chk(3'd2, 32'h8, "R8 flag set");
      chk_irq(1'b0, "R9 irq masked");
      wr(3'd2, 32'h1);
      wr(3'd2, 32'h5);
      chk(3'd2, 32'hD, "R9 ctrl");
      chk_irq(1'b1, "R9 irq asserted");
      wr(3'd2, 32'hD);
      chk(3'd2, 32'h5, "R10 flag cleared");
      chk_irq(1'b0, "R10 irq dropped");
      // R11 high byte
      wr(3'd4, 32'h01);
      wr(3'd2, 32'h3);
      chk(3'd4, 32'h0101, "R11 high byte");
      chk(3'd3, 32'h0101, "R11 low byte");
      // R10 set wins
      wr(3'd3, 32'h0);
      wr(3'd4, 32'h0);
      wr(3'd1, 32'h0);
      wr(3'd2, 32'h3);
      chk(3'd2, 32'h1, "R10 flag clear before run");
      wr(3'd2, 32'h0);
      cyc();
      wr(3'd2, 32'h9);
      chk(3'd2, 32'h9, "R10 set wins over clear");
      chk(3'd0, 32'h0, "R3 divide by 1 period 0");
      wr(3'd2, 32'h9);
      chk(3'd2, 32'h1, "R10 clear while stopped");
      cyc(); cyc();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule